// File: doc/BRIEF.md
# HI/LO Move Execute Unit

This combinational unit sits in the execute stage of a five-stage 32-bit pipeline and resolves six register move operations: two conditional moves (copy rs into the destination when rt is zero, or when rt is nonzero), two reads of the multiply/divide result registers HI and LO into a general register, and two writes of rs into HI or LO. It produces the final general-register write request and a HI/LO write bundle. That bundle travels down the pipeline and is committed in write-back.

Reads of HI and LO in execute can be stale. Older instructions that are still in the memory-access and write-back stages may be about to change those registers. The unit therefore takes the pending HI/LO writes of both later stages. It picks the youngest one, which is the memory-access stage first, then write-back, then the committed storage. The HI/LO storage, the decoder, the pipeline registers and the register file lie outside this block.

Top module: `hilo_move_exec`

## Requirements
- R1: While `rst` is high, every output is zero, including both write enables.
- R2: Function code 0x0A (zero-conditional move): when `rt_val` is zero, `gpr_we`=1, `gpr_addr`=`dst_in` and `gpr_data`=`rs_val`. Otherwise `gpr_we`=0, with the same address and data. `hl_we`=0.
- R3: Function code 0x0B (nonzero-conditional move) behaves the same way, except that it writes only when `rt_val` is nonzero.
- R4: Function code 0x10 (read HI): `gpr_we`=1, `gpr_addr`=`dst_in`, `gpr_data`= the forwarded HI value, `hl_we`=0.
- R5: Function code 0x12 (read LO): `gpr_we`=1, `gpr_addr`=`dst_in`, `gpr_data`= the forwarded LO value, `hl_we`=0.
- R6: Function code 0x11 (write HI): `gpr_we`=0, `gpr_addr`=0 and `gpr_data`=0. `hl_we`=1, `hl_hi`=`rs_val`, and `hl_lo`= the forwarded LO value.
- R7: Function code 0x13 (write LO): `gpr_we`=0, `gpr_addr`=0 and `gpr_data`=0. `hl_we`=1, `hl_lo`=`rs_val`, and `hl_hi`= the forwarded HI value.
- R8: The forwarded HI/LO pair is the memory-access stage pair when `mem_hl_we` is 1. Failing that, it is the write-back stage pair when `wb_hl_we` is 1. Otherwise it is `hi_q`/`lo_q`. A read that follows three back-to-back HI writes returns the last written value.
- R9: Any other function code: `gpr_we`=`wen_in`, `gpr_addr`=`dst_in`, `gpr_data`=0, `hl_we`=0, `hl_hi`=0 and `hl_lo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset; forces outputs to zero |
| op | input | 6 | Decoded function code |
| rs_val | input | 32 | rs operand value |
| rt_val | input | 32 | rt operand value |
| dst_in | input | 5 | Destination register address from decode |
| wen_in | input | 1 | Destination write enable from decode |
| hi_q | input | 32 | Committed HI value |
| lo_q | input | 32 | Committed LO value |
| mem_hl_we | input | 1 | Memory-access stage writes HI/LO |
| mem_hi | input | 32 | HI value pending in memory-access stage |
| mem_lo | input | 32 | LO value pending in memory-access stage |
| wb_hl_we | input | 1 | Write-back stage writes HI/LO |
| wb_hi | input | 32 | HI value pending in write-back stage |
| wb_lo | input | 32 | LO value pending in write-back stage |
| gpr_we | output | 1 | Final general-register write enable |
| gpr_addr | output | 5 | Final general-register address |
| gpr_data | output | 32 | Final general-register data |
| hl_we | output | 1 | HI/LO write enable |
| hl_hi | output | 32 | HI value to commit |
| hl_lo | output | 32 | LO value to commit |

## Verification
The embedded assertions are evaluated on every change. They check the quiet outputs during reset and the rt-zero gating of the two conditional moves. They also check that the HI/LO writes never request a general-register write, that the memory-access stage wins in forwarding, and that unrelated codes leave HI/LO alone. The bench sweeps every function code against all four forwarding states with zero and nonzero rt. This sweep is the only way to show the full three-level priority and that the untargeted register is preserved. A chained scenario feeds the unit's own HI/LO outputs through a modelled two-stage pipe, so that the final read of three consecutive HI writes is shown to see the youngest one.

// File: rtl/hilo_move_exec.sv
module hilo_move_exec #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            rst,
  input  logic [5:0]      op,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [AW-1:0]   dst_in,
  input  logic            wen_in,
  input  logic [XLEN-1:0] hi_q,
  input  logic [XLEN-1:0] lo_q,
  input  logic            mem_hl_we,
  input  logic [XLEN-1:0] mem_hi,
  input  logic [XLEN-1:0] mem_lo,
  input  logic            wb_hl_we,
  input  logic [XLEN-1:0] wb_hi,
  input  logic [XLEN-1:0] wb_lo,
  output logic            gpr_we,
  output logic [AW-1:0]   gpr_addr,
  output logic [XLEN-1:0] gpr_data,
  output logic            hl_we,
  output logic [XLEN-1:0] hl_hi,
  output logic [XLEN-1:0] hl_lo
);
  localparam logic [5:0] F_MOVZ = 6'h0A;
  localparam logic [5:0] F_MOVN = 6'h0B;
  localparam logic [5:0] F_MFHI = 6'h10;
  localparam logic [5:0] F_MTHI = 6'h11;
  localparam logic [5:0] F_MFLO = 6'h12;
  localparam logic [5:0] F_MTLO = 6'h13;

  wire [XLEN-1:0] hi_fwd  = mem_hl_we ? mem_hi : (wb_hl_we ? wb_hi : hi_q);
  wire [XLEN-1:0] lo_fwd  = mem_hl_we ? mem_lo : (wb_hl_we ? wb_lo : lo_q);
  wire            rt_zero = (rt_val == '0);

  always_comb begin
    gpr_we   = 1'b0;
    gpr_addr = '0;
    gpr_data = '0;
    hl_we    = 1'b0;
    hl_hi    = '0;
    hl_lo    = '0;
    if (!rst) begin
      unique case (op)
        F_MOVZ: begin
          gpr_we   = rt_zero;
          gpr_addr = dst_in;
          gpr_data = rs_val;
        end
        F_MOVN: begin
          gpr_we   = !rt_zero;
          gpr_addr = dst_in;
          gpr_data = rs_val;
        end
        F_MFHI: begin
          gpr_we   = 1'b1;
          gpr_addr = dst_in;
          gpr_data = hi_fwd;
        end
        F_MFLO: begin
          gpr_we   = 1'b1;
          gpr_addr = dst_in;
          gpr_data = lo_fwd;
        end
        F_MTHI: begin
          hl_we = 1'b1;
          hl_hi = rs_val;
          hl_lo = lo_fwd;
        end
        F_MTLO: begin
          hl_we = 1'b1;
          hl_hi = hi_fwd;
          hl_lo = rs_val;
        end
        default: begin
          gpr_we   = wen_in;
          gpr_addr = dst_in;
        end
      endcase
    end
  end

  always_comb begin
    if (rst) begin
      assert_rst_quiet_R1: assert (!gpr_we && !hl_we && gpr_addr == '0 && gpr_data == '0
                                   && hl_hi == '0 && hl_lo == '0);
    end else begin
      if (op == F_MOVZ)
        assert_movz_gate_R2: assert (gpr_we == (rt_val == '0) && !hl_we);
      if (op == F_MOVN)
        assert_movn_gate_R3: assert (gpr_we == (rt_val != '0) && !hl_we);
      if (op == F_MTHI)
        assert_mthi_nogpr_R6: assert (!gpr_we && gpr_addr == '0 && hl_we && hl_hi == rs_val);
      if (op == F_MTLO)
        assert_mtlo_nogpr_R7: assert (!gpr_we && gpr_addr == '0 && hl_we && hl_lo == rs_val);
      if (op == F_MFHI && mem_hl_we)
        assert_fwd_mem_first_R8: assert (gpr_data == mem_hi);
      if (op == F_MFLO && !mem_hl_we && wb_hl_we)
        assert_fwd_wb_second_R8: assert (gpr_data == wb_lo);
      if (!(op inside {F_MOVZ, F_MOVN, F_MFHI, F_MTHI, F_MFLO, F_MTLO}))
        assert_other_pass_R9: assert (!hl_we && gpr_we == wen_in && gpr_addr == dst_in);
    end
  end
endmodule

// File: tb/sim_hilo_move_exec.sv
module sim_hilo_move_exec;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic [5:0]  op;
  logic [31:0] rs_val, rt_val, hi_q, lo_q, mem_hi, mem_lo, wb_hi, wb_lo;
  logic [4:0]  dst_in;
  logic        wen_in, mem_hl_we, wb_hl_we;
  logic        gpr_we, hl_we;
  logic [4:0]  gpr_addr;
  logic [31:0] gpr_data, hl_hi, hl_lo;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hilo_move_exec u0 (.*);

  function automatic string tag_of(input logic [5:0] f);
    if (f == 6'h0A) return "R2";
    if (f == 6'h0B) return "R3";
    if (f == 6'h10) return "R4";
    if (f == 6'h12) return "R5";
    if (f == 6'h11) return "R6";
    if (f == 6'h13) return "R7";
    return "R9";
  endfunction

  task automatic check(input string tag);
    logic [31:0] fh, fl, e_gd, e_hh, e_hl;
    logic [4:0]  e_ga;
    logic        e_gw, e_hw;
    fh = mem_hl_we ? mem_hi : wb_hl_we ? wb_hi : hi_q;
    fl = mem_hl_we ? mem_lo : wb_hl_we ? wb_lo : lo_q;
    {e_gw, e_ga, e_gd, e_hw, e_hh, e_hl} = '0;
    if (!rst) begin
      if (op == 6'h0A || op == 6'h0B) begin
        e_gw = (op == 6'h0A) ? (rt_val == 0) : (rt_val != 0);
        e_ga = dst_in; e_gd = rs_val;
      end else if (op == 6'h10 || op == 6'h12) begin
        e_gw = 1; e_ga = dst_in; e_gd = (op == 6'h10) ? fh : fl;
      end else if (op == 6'h11) begin
        e_hw = 1; e_hh = rs_val; e_hl = fl;
      end else if (op == 6'h13) begin
        e_hw = 1; e_hh = fh; e_hl = rs_val;
      end else begin
        e_gw = wen_in; e_ga = dst_in;
      end
    end
    n_run++;
    if ({gpr_we, gpr_addr, gpr_data, hl_we, hl_hi, hl_lo} !== {e_gw, e_ga, e_gd, e_hw, e_hh, e_hl}) begin
      n_fail++;
      $display("FAIL %s op=%h: got we=%b a=%0d d=%h hw=%b hi=%h lo=%h exp we=%b a=%0d d=%h hw=%b hi=%h lo=%h",
               tag, op, gpr_we, gpr_addr, gpr_data, hl_we, hl_hi, hl_lo,
               e_gw, e_ga, e_gd, e_hw, e_hh, e_hl);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [8] = '{6'h0A, 6'h0B, 6'h10, 6'h11, 6'h12, 6'h13, 6'h20, 6'h00};
    rst = 1; op = 6'h10; rs_val = 32'hDEAD_BEEF; rt_val = 0; dst_in = 5'd7; wen_in = 1;
    hi_q = 32'h1111_0001; lo_q = 32'h2222_0002;
    mem_hl_we = 1; mem_hi = 32'h3333_0003; mem_lo = 32'h4444_0004;
    wb_hl_we = 1; wb_hi = 32'h5555_0005; wb_lo = 32'h6666_0006;
    @(negedge clk); check("R1");
    op = 6'h11; @(negedge clk); check("R1");
    op = 6'h0A; @(negedge clk); check("R1");
    rst = 0;

    // R8 forwarding priority is covered for every op by the fw sweep
    for (int k = 0; k < 8; k++)
      for (int fw = 0; fw < 4; fw++)
        for (int z = 0; z < 2; z++) begin
          @(negedge clk);
          op = ops[k];
          mem_hl_we = fw[1]; wb_hl_we = fw[0];
          rt_val = z ? 32'h0 : (32'h0000_0100 << k) + fw;
          rs_val = 32'hA000_0000 + (k << 8) + (fw << 4) + z;
          dst_in = 5'(3 * k + fw + 1);
          wen_in = z[0] ^ fw[0];
          hi_q = 32'h0100_0000 + k; lo_q = 32'h0200_0000 + k;
          mem_hi = 32'h0300_0000 + fw; mem_lo = 32'h0400_0000 + fw;
          wb_hi  = 32'h0500_0000 + z;  wb_lo  = 32'h0600_0000 + z;
          #1; check(tag_of(op));
        end

    // R8: mthi x3 then mfhi through a modelled two-stage pipe
    begin
      logic        p_mw, p_ww;
      logic [31:0] p_mh, p_ml, p_wh, p_wl;
      logic [31:0] vals [3] = '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_0000};
      p_mw = 0; p_ww = 0; p_mh = 0; p_ml = 0; p_wh = 0; p_wl = 0;
      hi_q = 32'h1234_5678; lo_q = 32'h8765_4321;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        op = (i < 3) ? 6'h11 : 6'h10;
        rs_val = (i < 3) ? vals[i] : 32'h0; dst_in = 5'd4;
        mem_hl_we = p_mw; mem_hi = p_mh; mem_lo = p_ml;
        wb_hl_we = p_ww; wb_hi = p_wh; wb_lo = p_wl;
        #1;
        check("R8");
        if (i == 3) begin
          n_run++;
          if (gpr_data !== 32'hFFFF_0000) begin
            n_fail++;
            $display("FAIL R8 chained read: got %h exp %h", gpr_data, 32'hFFFF_0000);
          end
        end
        if (p_ww) begin hi_q = p_wh; lo_q = p_wl; end
        p_ww = p_mw; p_wh = p_mh; p_wl = p_ml;
        p_mw = hl_we; p_mh = hl_hi; p_ml = hl_lo;
      end
    end

    @(negedge clk); rst = 1; #1; check("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule